// File: doc/BRIEF.md
# Dual-Clock Bus-Matching FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Each side can be 9 or 18 bits wide, and the pair of widths, together with a byte-order choice, is latched while master reset is held. When one side is wide and the other narrow, the block splits each 18-bit input word into two 9-bit bytes or joins two bytes into one 18-bit output word. The byte order can be big-endian, where the upper half goes first, or little-endian, where the lower half goes first.

Storage is an internal array of 9-bit units. The write and read positions are kept as unit counters. Each counter passes to the other clock domain as a Gray-style code through a two-flop synchroniser. The write domain produces the full and half-full flags and the read domain produces the empty flag. Partial reset drops all stored data and keeps the latched configuration. A retransmit strobe rewinds the reader to the first word stored since the last reset, so the data can be read again at once. An output-enable input gates the read data and its valid flag.

Top module: `busMatchFifo`

## Requirements
- R1: `cfgInWide`, `cfgOutWide` and `cfgBigEndian` are latched on clock edges while `masterRst` is high. The latched values stay in force through later partial resets until the next master reset.
- R2: In 9-to-9 and 18-to-18 operation, words come out unchanged and in the order they were written.
- R3: A 9-bit input uses `wrData[8:0]` and ignores bits 17:9. A 9-bit output drives `rdData[17:9]` to zero. With big-endian order, bits 17:9 of a wide word are the earlier byte; with little-endian order, bits 8:0 are the earlier byte. This holds both for splitting and for packing.
- R4: `empty` is high while fewer 9-bit units are stored than one output word needs. For example, one byte stored in 9-to-18 operation keeps `empty` high.
- R5: Capacity is DEPTH = 2^ADDR_W units, which is 32 by default. `full` is high when the free space is smaller than one input word. `halfFull` is high when at least DEPTH/2 units are stored. In 18-bit input mode the write position only ever advances by two units.
- R6: A write while `full` is high and a read while `empty` is high are ignored. Neither changes the stored data, the pointers or `rdData`.
- R7: A read accepted on a `rdClk` edge presents its word on `rdData` after that same edge, and not before it.
- R8: A `rdClk` edge with `retransmit` high sets the read position back to the first word stored since the last reset. The next accepted read returns that word. This is valid while writes are idle and the buffer has not wrapped.
- R9: Partial reset empties the buffer (`empty` high, `full` and `halfFull` low) and keeps the configuration from R1.
- R10: After master reset, `empty` is 1, `full` is 0, `halfFull` is 0, `rdData` is 0 and `rdValid` is 0.
- R11: While `outEn` is low, `rdData` is all zero and `rdValid` is 0. While `outEn` is high, `rdValid` is 1 once a word has been read since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| masterRst | input | 1 | Asynchronous master reset, active high; configuration is latched while it is high |
| partialRst | input | 1 | Asynchronous partial reset, active high; keeps the configuration |
| cfgInWide | input | 1 | 1 selects an 18-bit input, 0 selects a 9-bit input |
| cfgOutWide | input | 1 | 1 selects an 18-bit output, 0 selects a 9-bit output |
| cfgBigEndian | input | 1 | 1 makes the upper half the earlier byte |
| wrEn | input | 1 | Write request, sampled on wrClk |
| wrData | input | 18 | Write data |
| rdEn | input | 1 | Read request, sampled on rdClk |
| retransmit | input | 1 | Rewinds the reader to the first stored word |
| outEn | input | 1 | Output gate |
| rdData | output | 18 | Read data, gated by outEn |
| rdValid | output | 1 | A read word is held and outEn is high |
| empty | output | 1 | No complete output word is stored (read domain) |
| full | output | 1 | A complete input word cannot be accepted (write domain) |
| halfFull | output | 1 | At least half the units are in use (write domain) |

## Verification
The hardest states to reach are the ones where the fill level sits one unit away from a flag threshold on a side whose word is two units wide. The first is 31 units stored with an 18-bit writer, where `full` must stay high. The second is a single byte stored with an 18-bit reader, where `empty` must stay high. Reaching them takes a mixed-width configuration plus odd numbers of narrow operations on the other side. After each step the stimulus waits long enough for the pointer to cross into the flag's clock domain. The retransmit rewind also needs a partially drained buffer with the writer idle, so the bench writes, reads part of the data, pulses `retransmit` and reads again.

// File: rtl/bmfPkg.sv
package bmfPkg;

  // Configuration latched during master reset.
  typedef struct packed {
    logic inWide;
    logic outWide;
    logic bigEnd;
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrStb;
    logic wrWide;
    logic wrBigEnd;
    logic rdStb;
    logic rdWide;
    logic rdBigEnd;
  } strobes_t;

endpackage

// File: rtl/bmfSync.sv
module bmfSync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      dOut   <= '0;
    end else begin
      stage1 <= dIn;
      dOut   <= stage1;
    end
  end
endmodule

// File: rtl/bmfCtrl.sv
module bmfCtrl
  import bmfPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  cfg_t              cfgIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              retransmit,
  output strobes_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              empty,
  output logic              full,
  output logic              halfFull
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // A wide side moves by two units with bit 0 fixed at zero, so only the
  // upper bits are Gray coded. That keeps one bit changing per step.
  function automatic logic [PW-1:0] toCode(input logic [PW-1:0] p, input logic wide);
    logic [PW-1:0] g;
    if (wide) g = {p[PW-1:1] ^ (p[PW-1:1] >> 1), 1'b0};
    else      g = p ^ (p >> 1);
    return g;
  endfunction

  function automatic logic [PW-1:0] fromCode(input logic [PW-1:0] g, input logic wide);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    if (wide) b[0] = 1'b0;
    return b;
  endfunction

  logic anyRst;
  assign anyRst = masterRst | partialRst;

  cfg_t wrCfg, rdCfg;
  always_ff @(posedge wrClk) if (masterRst) wrCfg <= cfgIn;
  always_ff @(posedge rdClk) if (masterRst) rdCfg <= cfgIn;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtr, wrCode, wrNext, wrStep, usedW, freeW, rdCodeW, rdPtrInW;
  logic          wrAccept;

  assign wrStep   = wrCfg.inWide ? PW'(2) : PW'(1);
  assign rdPtrInW = fromCode(rdCodeW, wrCfg.outWide);
  assign usedW    = wrPtr - rdPtrInW;
  assign freeW    = PW'(DEPTH) - usedW;
  assign full     = freeW < wrStep;
  assign halfFull = usedW >= PW'(DEPTH / 2);
  assign wrAccept = wrEn & ~full;
  assign wrNext   = wrAccept ? wrPtr + wrStep : wrPtr;

  always_ff @(posedge wrClk or posedge anyRst) begin
    if (anyRst) begin
      wrPtr  <= '0;
      wrCode <= '0;
    end else begin
      wrPtr  <= wrNext;
      wrCode <= toCode(wrNext, wrCfg.inWide);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdPtr, rdCode, rdNext, rdStep, usedR, wrCodeR, wrPtrInR;
  logic          rdAccept;

  assign rdStep   = rdCfg.outWide ? PW'(2) : PW'(1);
  assign wrPtrInR = fromCode(wrCodeR, rdCfg.inWide);
  assign usedR    = wrPtrInR - rdPtr;
  assign empty    = usedR < rdStep;
  assign rdAccept = rdEn & ~empty & ~retransmit;
  assign rdNext   = retransmit ? '0 : (rdAccept ? rdPtr + rdStep : rdPtr);

  always_ff @(posedge rdClk or posedge anyRst) begin
    if (anyRst) begin
      rdPtr  <= '0;
      rdCode <= '0;
    end else begin
      rdPtr  <= rdNext;
      rdCode <= toCode(rdNext, rdCfg.outWide);
    end
  end

  bmfSync #(.W(PW)) u_rdToWr (.clk(wrClk), .rst(anyRst), .dIn(rdCode), .dOut(rdCodeW));
  bmfSync #(.W(PW)) u_wrToRd (.clk(rdClk), .rst(anyRst), .dIn(wrCode), .dOut(wrCodeR));

  assign wrAddr = wrPtr[ADDR_W-1:0];
  assign rdAddr = rdPtr[ADDR_W-1:0];

  always_comb begin
    stb.wrStb    = wrAccept;
    stb.wrWide   = wrCfg.inWide;
    stb.wrBigEnd = wrCfg.bigEnd;
    stb.rdStb    = rdAccept;
    stb.rdWide   = rdCfg.outWide;
    stb.rdBigEnd = rdCfg.bigEnd;
  end

  // ---------------- assertions ----------------
  AST_CFG_HOLD: assert property (@(posedge wrClk) disable iff (masterRst)
    1'b1 |=> $stable(wrCfg)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (anyRst)
    usedW <= PW'(DEPTH)); // R5
  AST_WIDE_ALIGN: assert property (@(posedge wrClk) disable iff (anyRst)
    wrCfg.inWide |-> !wrPtr[0]); // R5
  AST_FULL_HOLD: assert property (@(posedge wrClk) disable iff (anyRst)
    (full && wrEn) |=> $stable(wrPtr)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge rdClk) disable iff (anyRst)
    (empty && rdEn && !retransmit) |=> $stable(rdPtr)); // R6
  AST_RT_RESTART: assert property (@(posedge rdClk) disable iff (anyRst)
    retransmit |=> (rdPtr == '0)); // R8
endmodule

// File: rtl/bmfData.sv
module bmfData
  import bmfPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              anyRst,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [17:0]       wrData,
  input  logic              outEn,
  output logic [17:0]       rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [8:0]        mem [DEPTH];
  logic [8:0]        wrFirst, wrSecond, rdFirst, rdSecond;
  logic [ADDR_W-1:0] wrAddrNext, rdAddrNext;
  logic [17:0]       rdWord, rdReg;
  logic              loaded;

  assign wrAddrNext = wrAddr + 1'b1;
  assign rdAddrNext = rdAddr + 1'b1;

  // Split on the write side: pick which half is stored first.
  always_comb begin
    if (stb.wrWide && stb.wrBigEnd) begin
      wrFirst  = wrData[17:9];
      wrSecond = wrData[8:0];
    end else begin
      wrFirst  = wrData[8:0];
      wrSecond = wrData[17:9];
    end
  end

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) begin
      mem[wrAddr] <= wrFirst;
      if (stb.wrWide) mem[wrAddrNext] <= wrSecond;
    end
  end

  // Pack on the read side.
  assign rdFirst  = mem[rdAddr];
  assign rdSecond = mem[rdAddrNext];

  always_comb begin
    if (!stb.rdWide)        rdWord = {9'd0, rdFirst};
    else if (stb.rdBigEnd)  rdWord = {rdFirst, rdSecond};
    else                    rdWord = {rdSecond, rdFirst};
  end

  always_ff @(posedge rdClk or posedge anyRst) begin
    if (anyRst) begin
      rdReg  <= '0;
      loaded <= 1'b0;
    end else if (stb.rdStb) begin
      rdReg  <= rdWord;
      loaded <= 1'b1;
    end
  end

  assign rdData  = outEn ? rdReg : '0;
  assign rdValid = outEn & loaded;
endmodule

// File: rtl/busMatchFifo.sv
module busMatchFifo
  import bmfPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        masterRst,
  input  logic        partialRst,
  input  logic        cfgInWide,
  input  logic        cfgOutWide,
  input  logic        cfgBigEndian,
  input  logic        wrEn,
  input  logic [17:0] wrData,
  input  logic        rdEn,
  input  logic        retransmit,
  input  logic        outEn,
  output logic [17:0] rdData,
  output logic        rdValid,
  output logic        empty,
  output logic        full,
  output logic        halfFull
);
  cfg_t              cfgIn;
  strobes_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              anyRst;

  assign cfgIn  = '{inWide: cfgInWide, outWide: cfgOutWide, bigEnd: cfgBigEndian};
  assign anyRst = masterRst | partialRst;

  bmfCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .cfgIn(cfgIn), .wrEn(wrEn), .rdEn(rdEn), .retransmit(retransmit),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  bmfData #(.ADDR_W(ADDR_W)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .anyRst(anyRst), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/busMatchFifo_tb.sv
`timescale 1ns/1ps
module busMatchFifo_tb;
  logic wrClk = 1'b0, rdClk = 1'b0;
  logic masterRst = 1'b1, partialRst = 1'b0;
  logic cfgInWide = 1'b0, cfgOutWide = 1'b0, cfgBigEndian = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, retransmit = 1'b0, outEn = 1'b1;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic rdValid, empty, full, halfFull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 wrClk = ~wrClk;
  always #6 rdClk = ~rdClk;

  busMatchFifo u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .cfgInWide(cfgInWide), .cfgOutWide(cfgOutWide), .cfgBigEndian(cfgBigEndian),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .retransmit(retransmit), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid), .empty(empty), .full(full), .halfFull(halfFull)
  );

  typedef struct packed {
    logic        iw, ow, be;
    logic [1:0]  nIn;
    logic [17:0] in0, in1;
    logic [1:0]  nOut;
    logic [17:0] out0, out1;
  } vec_t;

  // Bytes A=1A5, B=0C3; {A,B}=34AC3, {B,A}=187A5. Narrow inputs carry junk in 17:9.
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 2'd2, 18'h3E1A5, 18'h0AAC3, 2'd2, 18'h001A5, 18'h000C3},
    '{1'b0, 1'b0, 1'b0, 2'd2, 18'h3E1A5, 18'h0AAC3, 2'd2, 18'h001A5, 18'h000C3},
    '{1'b0, 1'b1, 1'b1, 2'd2, 18'h3E1A5, 18'h0AAC3, 2'd1, 18'h34AC3, 18'h00000},
    '{1'b0, 1'b1, 1'b0, 2'd2, 18'h3E1A5, 18'h0AAC3, 2'd1, 18'h187A5, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 2'd1, 18'h34AC3, 18'h00000, 2'd2, 18'h001A5, 18'h000C3},
    '{1'b1, 1'b0, 1'b0, 2'd1, 18'h34AC3, 18'h00000, 2'd2, 18'h000C3, 18'h001A5},
    '{1'b1, 1'b1, 1'b1, 2'd2, 18'h34AC3, 18'h12345, 2'd2, 18'h34AC3, 18'h12345},
    '{1'b1, 1'b1, 1'b0, 2'd2, 18'h34AC3, 18'h12345, 2'd2, 18'h34AC3, 18'h12345}
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic partial, input logic iw, input logic ow, input logic be);
    @(negedge wrClk);
    cfgInWide = iw; cfgOutWide = ow; cfgBigEndian = be;
    wrEn = 1'b0; rdEn = 1'b0; retransmit = 1'b0;
    if (partial) partialRst = 1'b1; else masterRst = 1'b1;
    repeat (3) @(negedge rdClk);
    @(negedge wrClk);
    #1;
    masterRst = 1'b0; partialRst = 1'b0;
    @(negedge wrClk);
  endtask

  task automatic doWrite(input logic [17:0] d);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic doRead();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge rdClk);
    repeat (5) @(negedge wrClk);
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state (R10)
    doReset(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 empty", 18'(empty), 18'd1);
    chk("R10 full", 18'(full), 18'd0);
    chk("R10 halfFull", 18'(halfFull), 18'd0);
    chk("R10 rdData", rdData, 18'd0);
    chk("R10 rdValid", 18'(rdValid), 18'd0);

    // Width and byte-order table (R1 R2 R3 R4)
    for (int v = 0; v < 8; v++) begin
      doReset(1'b0, VECS[v].iw, VECS[v].ow, VECS[v].be);
      doWrite(VECS[v].in0);
      if (VECS[v].nIn == 2'd2) doWrite(VECS[v].in1);
      settle();
      doRead();
      chk($sformatf("R2/R3 vec%0d word0", v), rdData, VECS[v].out0);
      if (VECS[v].nOut == 2'd2) begin
        doRead();
        chk($sformatf("R2/R3 vec%0d word1", v), rdData, VECS[v].out1);
      end
      settle();
      chk($sformatf("R4 vec%0d drained", v), 18'(empty), 18'd1);
    end

    // Capacity, half-full and ignored write while full, 9->9 (R5 R6)
    doReset(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) doWrite(18'(i + 3));
    chk("R5 halfFull at 15", 18'(halfFull), 18'd0);
    doWrite(18'd18);
    chk("R5 halfFull at 16", 18'(halfFull), 18'd1);
    for (int i = 16; i < 31; i++) doWrite(18'(i + 3));
    chk("R5 full at 31", 18'(full), 18'd0);
    doWrite(18'd34);
    chk("R5 full at 32", 18'(full), 18'd1);
    doWrite(18'h1FF);
    settle();
    for (int i = 0; i < 32; i++) begin
      doRead();
      chk($sformatf("R6 byte %0d after dropped write", i), rdData, 18'(i + 3));
    end
    settle();
    chk("R6 empty after drain", 18'(empty), 18'd1);
    chk("R5 full clear after drain", 18'(full), 18'd0);
    doRead();
    chk("R6 read while empty keeps rdData", rdData, 18'd34);

    // 18-bit writer: full when only one unit free (R5)
    doReset(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 15; i++) doWrite(18'(i));
    chk("R5 wide full at 30", 18'(full), 18'd0);
    doWrite(18'd15);
    chk("R5 wide full at 32", 18'(full), 18'd1);
    settle();
    doRead();
    settle();
    chk("R5 wide full with one unit free", 18'(full), 18'd1);
    doRead();
    settle();
    chk("R5 wide full with two units free", 18'(full), 18'd0);

    // 18-bit reader with one byte stored; read latency (R4 R7)
    doReset(1'b0, 1'b0, 1'b1, 1'b1);
    doWrite(18'h1A5);
    settle();
    chk("R4 one byte keeps empty", 18'(empty), 18'd1);
    doWrite(18'h0C3);
    settle();
    chk("R4 two bytes clear empty", 18'(empty), 18'd0);
    @(negedge rdClk);
    rdEn = 1'b1;
    #2;
    chk("R7 rdData before edge", rdData, 18'd0);
    @(negedge rdClk);
    rdEn = 1'b0;
    chk("R7 rdData after edge", rdData, 18'h34AC3);

    // Retransmit (R8)
    doReset(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) doWrite(18'(10 + i));
    settle();
    doRead();
    chk("R8 first read", rdData, 18'd10);
    doRead();
    chk("R8 second read", rdData, 18'd11);
    @(negedge rdClk);
    retransmit = 1'b1;
    @(negedge rdClk);
    retransmit = 1'b0;
    doRead();
    chk("R8 read after retransmit", rdData, 18'd10);
    doRead();
    chk("R8 second read after retransmit", rdData, 18'd11);

    // Partial reset keeps configuration (R1 R9)
    doReset(1'b0, 1'b1, 1'b0, 1'b0);
    doWrite(18'h34AC3);
    settle();
    doReset(1'b1, 1'b0, 1'b0, 1'b1);
    settle();
    chk("R9 empty after partial reset", 18'(empty), 18'd1);
    chk("R9 halfFull after partial reset", 18'(halfFull), 18'd0);
    doWrite(18'h34AC3);
    settle();
    doRead();
    chk("R1 kept little-endian low byte", rdData, 18'h000C3);
    doRead();
    chk("R1 kept wide input high byte", rdData, 18'h001A5);

    // Output gate (R11)
    @(negedge rdClk);
    outEn = 1'b0;
    #1;
    chk("R11 rdData gated", rdData, 18'd0);
    chk("R11 rdValid gated", 18'(rdValid), 18'd0);
    outEn = 1'b1;
    #1;
    chk("R11 rdData ungated", rdData, 18'h001A5);
    chk("R11 rdValid ungated", 18'(rdValid), 18'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule